// File: doc/BRIEF.md
# Multitemplate VLIW Instruction Decoder

This block sits one stage behind the fetch aligner of a VLIW core. Each cycle it looks at one instruction held right-justified at bit 0 of the instruction register. It reads a 2-bit template code from the low bits of that instruction and looks the code up in a constant template table. The table gives the instruction length in 16-bit quanta, which functional units the template carries an operation slot for, where each slot starts, and where the optional multinoop count sits. Slots are copied into registered per-unit outputs. Units with no slot in the template get a noop, meaning the valid bit is clear and the fields are zero.

The aligner offers an instruction with `ir_vld_i`. The decoder answers with the combinational `adv_o`, together with `len_o` and `eop_o`, to say that the instruction is consumed this cycle. If the template carries a non-zero multinoop count N, the decoder drops `adv_o` for the next N cycles and issues N all-noop cycles, flagged by `mnop_o`, without fetching anything. An unassigned template code is consumed as a one-quantum instruction that issues only noops and raises `illegal_o`.

Top module: `vliw_tmpl_dec`

## Requirements
- R1: While reset is held, and in the first cycle after it, `op_vld_o`, `op_grp_o`, `op_body_o`, `mnop_o` and `illegal_o` are all zero.
- R2: Instruction bit 0 is the end-of-packet flag, and bits 2:1 are the template code. `eop_o` equals bit 0 when `adv_o` is high and is 0 otherwise.
- R3: When `adv_o` is high, `len_o` gives the length in quanta: code 0 gives 3, code 1 gives 1, code 2 gives 2, and code 3 gives 1.
- R4: The cycle after a consumed instruction, `op_vld_o` shows the units present in its template. Code 0 sets units 0, 1 and 2. Code 1 sets unit 1 only. Code 2 sets units 0 and 2. Code 3 sets none.
- R5: Each present slot is 12 bits wide and taken from a fixed start bit. For code 0, unit 0 starts at bit 3, unit 1 at bit 15 and unit 2 at bit 27. For code 1, unit 1 starts at bit 3. For code 2, unit 0 starts at bit 3 and unit 2 at bit 15.
- R6: Within a slot, bits 1:0 are the opgroup select and appear on that unit's `op_grp_o` field. Bits 11:2 are the opcode and operands and appear on `op_body_o`.
- R7: A unit whose valid bit is clear has all-zero group and body fields.
- R8: The multinoop count N is a 3-bit field at bit 39 for code 0 and at bit 27 for code 2. After the instruction cycle, exactly N cycles follow in which `mnop_o` is 1 and every unit is a noop.
- R9: `adv_o` is low while multinoop cycles remain to be issued. An instruction offered during that time is not consumed and has no effect on the outputs.
- R10: Code 1 has no multinoop field. It behaves as N = 0 whatever its upper bits hold.
- R11: Code 3 is consumed in one cycle. The next cycle shows `illegal_o` high, no unit valid, and no multinoop cycles follow.
- R12: A cycle with no consumed instruction and no pending multinoop is followed by a cycle with all units noop and `mnop_o` and `illegal_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_i | input | 64 | Instruction register, instruction starting at bit 0 |
| ir_vld_i | input | 1 | Instruction register holds an instruction |
| adv_o | output | 1 | Instruction consumed this cycle |
| len_o | output | 3 | Consumed length in 16-bit quanta |
| eop_o | output | 1 | Skip the rest of the packet after this instruction |
| op_vld_o | output | 3 | Per-unit slot valid, noop when clear |
| op_grp_o | output | 6 | Per-unit opgroup select, 2 bits per unit |
| op_body_o | output | 30 | Per-unit opcode and operands, 10 bits per unit |
| mnop_o | output | 1 | Current cycle is an implicit multinoop cycle |
| illegal_o | output | 1 | Current cycle comes from an unassigned template code |

## Verification
The bench targets the largest count N = 7, N = 0, and the back-to-back case where the next instruction waits behind a multinoop run. A counter that is off by one shows up there as one empty cycle too many or too few, or as the waiting instruction being issued early. Code 1 is driven with random bits where other templates keep their count, so a decoder that reads a count from the wrong template would insert empty cycles. Illegal codes are driven with random upper bits, and any leaked slot or count shows up as a unit valid or an `mnop_o` pulse. Absent units are compared field by field, which exposes a design that gates only the valid bit and passes stale or shifted bits through.

// File: rtl/vliw_dec_pkg.sv
package vliw_dec_pkg;
  localparam int IW       = 64;
  localparam int N_FU     = 3;
  localparam int SLOT_W   = 12;
  localparam int GRP_W    = 2;
  localparam int BODY_W   = SLOT_W - GRP_W;
  localparam int TSEL_W   = 2;
  localparam int TSEL_LSB = 1;
  localparam int N_TMPL   = 1 << TSEL_W;
  localparam int MNOP_W   = 3;
  localparam int LEN_W    = 3;
  localparam int POS_W    = $clog2(IW);

  typedef struct packed {
    logic                       legal;
    logic [LEN_W-1:0]           len_q;
    logic [N_FU-1:0]            fu_mask;
    logic                       has_mn;
    logic [POS_W-1:0]           mn_pos;
    logic [N_FU-1:0][POS_W-1:0] slot_pos;
  } tmpl_t;

  localparam logic [LEN_W-1:0] ILL_LEN = LEN_W'(1);

  localparam tmpl_t TMPL_TAB [N_TMPL] = '{
    '{legal: 1'b1, len_q: 3'd3, fu_mask: 3'b111, has_mn: 1'b1, mn_pos: 6'd39,
      slot_pos: '{6'd27, 6'd15, 6'd3}},
    '{legal: 1'b1, len_q: 3'd1, fu_mask: 3'b010, has_mn: 1'b0, mn_pos: 6'd0,
      slot_pos: '{6'd0, 6'd3, 6'd0}},
    '{legal: 1'b1, len_q: 3'd2, fu_mask: 3'b101, has_mn: 1'b1, mn_pos: 6'd27,
      slot_pos: '{6'd15, 6'd0, 6'd3}},
    '{legal: 1'b0, len_q: 3'd0, fu_mask: 3'b000, has_mn: 1'b0, mn_pos: 6'd0,
      slot_pos: '{6'd0, 6'd0, 6'd0}}
  };
endpackage

// File: rtl/tmpl_lookup.sv
module tmpl_lookup
  import vliw_dec_pkg::*;
#(
  parameter tmpl_t TAB [N_TMPL] = TMPL_TAB
) (
  input  logic [TSEL_W-1:0] tsel_i,
  output tmpl_t             ent_o
);
  assign ent_o = TAB[tsel_i];
endmodule

// File: rtl/slot_extract.sv
module slot_extract
  import vliw_dec_pkg::*;
(
  input  logic [IW-1:0]                   ir_i,
  input  logic [N_FU-1:0]                 mask_i,
  input  logic [N_FU-1:0][POS_W-1:0]      pos_i,
  output logic [N_FU-1:0]                 vld_o,
  output logic [N_FU-1:0][SLOT_W-1:0]     slot_o
);
  for (genvar g = 0; g < N_FU; g++) begin : g_fu
    logic [SLOT_W-1:0] raw;
    assign raw       = SLOT_W'(ir_i >> pos_i[g]);
    assign vld_o[g]  = mask_i[g];
    assign slot_o[g] = mask_i[g] ? raw : '0;
  end
endmodule

// File: rtl/mnop_seq.sv
module mnop_seq
  import vliw_dec_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MNOP_W-1:0] n_i,
  output logic              busy_o,
  output logic              mnop_o
);
  logic [MNOP_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      mnop_o <= 1'b0;
    end else if (load_i) begin
      cnt_q  <= n_i;
      mnop_o <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q  <= cnt_q - 1'b1;
      mnop_o <= 1'b1;
    end else begin
      mnop_o <= 1'b0;
    end
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/vliw_tmpl_dec.sv
module vliw_tmpl_dec
  import vliw_dec_pkg::*;
#(
  parameter tmpl_t TAB [N_TMPL] = TMPL_TAB
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [IW-1:0]          ir_i,
  input  logic                   ir_vld_i,
  output logic                   adv_o,
  output logic [LEN_W-1:0]       len_o,
  output logic                   eop_o,
  output logic [N_FU-1:0]        op_vld_o,
  output logic [N_FU*GRP_W-1:0]  op_grp_o,
  output logic [N_FU*BODY_W-1:0] op_body_o,
  output logic                   mnop_o,
  output logic                   illegal_o
);
  tmpl_t                       ent;
  logic                        seq_busy;
  logic [N_FU-1:0]             fu_vld;
  logic [N_FU-1:0][SLOT_W-1:0] fu_slot;
  logic [MNOP_W-1:0]           mn_raw, mn_cnt;

  tmpl_lookup #(.TAB(TAB)) i_lookup (
    .tsel_i (ir_i[TSEL_LSB +: TSEL_W]),
    .ent_o  (ent)
  );

  slot_extract i_extract (
    .ir_i   (ir_i),
    .mask_i (ent.legal ? ent.fu_mask : '0),
    .pos_i  (ent.slot_pos),
    .vld_o  (fu_vld),
    .slot_o (fu_slot)
  );

  assign mn_raw = MNOP_W'(ir_i >> ent.mn_pos);
  assign mn_cnt = (ent.legal && ent.has_mn) ? mn_raw : '0;

  assign adv_o = ir_vld_i && !seq_busy;
  assign len_o = ent.legal ? ent.len_q : ILL_LEN;
  assign eop_o = adv_o && ir_i[0];

  mnop_seq i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (adv_o),
    .n_i    (mn_cnt),
    .busy_o (seq_busy),
    .mnop_o (mnop_o)
  );

  logic [N_FU-1:0]             vld_q;
  logic [N_FU-1:0][SLOT_W-1:0] slot_q;
  logic                        ill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= '0;
      slot_q <= '0;
      ill_q  <= 1'b0;
    end else if (adv_o) begin
      vld_q  <= fu_vld;
      slot_q <= fu_slot;
      ill_q  <= !ent.legal;
    end else begin
      vld_q  <= '0;
      slot_q <= '0;
      ill_q  <= 1'b0;
    end
  end

  assign op_vld_o  = vld_q;
  assign illegal_o = ill_q;

  for (genvar g = 0; g < N_FU; g++) begin : g_out
    assign op_grp_o[g*GRP_W +: GRP_W]    = slot_q[g][GRP_W-1:0];
    assign op_body_o[g*BODY_W +: BODY_W] = slot_q[g][SLOT_W-1:GRP_W];
  end
endmodule

// File: rtl/vliw_tmpl_dec_chk.sv
module vliw_tmpl_dec_chk
  import vliw_dec_pkg::*;
(
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   adv_o,
  input logic [LEN_W-1:0]       len_o,
  input logic [N_FU-1:0]        op_vld_o,
  input logic [N_FU*GRP_W-1:0]  op_grp_o,
  input logic [N_FU*BODY_W-1:0] op_body_o,
  input logic                   mnop_o,
  input logic                   illegal_o,
  input logic                   busy_i
);
  a_r3_len_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_o |-> (len_o >= LEN_W'(1) && len_o <= LEN_W'(3)));

  a_r8_mnop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mnop_o |-> (op_vld_o == '0 && !illegal_o));

  a_r8_issue_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_o |=> !mnop_o);

  a_r9_hold_adv: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !adv_o);

  a_r11_ill_noop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (op_vld_o == '0 && !mnop_o));

  a_r12_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_o && !busy_i) |=> (op_vld_o == '0 && !mnop_o && !illegal_o));

  for (genvar g = 0; g < N_FU; g++) begin : g_abs
    a_r7_absent_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !op_vld_o[g] |-> (op_grp_o[g*GRP_W +: GRP_W] == '0 &&
                        op_body_o[g*BODY_W +: BODY_W] == '0));
  end
endmodule

bind vliw_tmpl_dec vliw_tmpl_dec_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .adv_o     (adv_o),
  .len_o     (len_o),
  .op_vld_o  (op_vld_o),
  .op_grp_o  (op_grp_o),
  .op_body_o (op_body_o),
  .mnop_o    (mnop_o),
  .illegal_o (illegal_o),
  .busy_i    (seq_busy)
);

// File: tb/test_vliw_tmpl_dec.sv
module test_vliw_tmpl_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] ir = '0;
  logic        vld = 1'b0;
  logic        adv, eop, mnop, ill;
  logic [2:0]  len, opv;
  logic [5:0]  grp;
  logic [29:0] body;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vliw_tmpl_dec i_vliw_tmpl_dec (
    .clk_i(clk), .rst_ni(rst_n), .ir_i(ir), .ir_vld_i(vld),
    .adv_o(adv), .len_o(len), .eop_o(eop), .op_vld_o(opv),
    .op_grp_o(grp), .op_body_o(body), .mnop_o(mnop), .illegal_o(ill)
  );

  // reference model state
  int        m_cnt = 0;
  bit [2:0]  e_vld = '0;
  bit [11:0] e_slot [3];
  bit        e_mn = 0, e_ill = 0;
  int        last_code = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int t_mask(input int c);
    case (c) 0: return 7; 1: return 2; 2: return 5; default: return 0; endcase
  endfunction
  function automatic int t_len(input int c);
    case (c) 0: return 3; 1: return 1; 2: return 2; default: return 1; endcase
  endfunction
  function automatic int t_pos(input int c, input int u);
    if (c == 0) return 3 + 12 * u;
    if (c == 1) return 3;
    return (u == 0) ? 3 : 15;
  endfunction
  function automatic int t_n(input logic [63:0] w);
    int c = int'(w[2:1]);
    if (c == 0) return int'((w >> 39) & 64'h7);
    if (c == 2) return int'((w >> 27) & 64'h7);
    return 0;
  endfunction

  // model of the edge that just passed, then registered-output compare
  task automatic edge_chk();
    @(negedge clk);
    if (vld && m_cnt == 0) begin
      int c = int'(ir[2:1]);
      last_code = c;
      for (int u = 0; u < 3; u++) begin
        e_vld[u]  = t_mask(c)[u];
        e_slot[u] = e_vld[u] ? 12'((ir >> t_pos(c, u)) & 64'hfff) : 12'h0;
      end
      e_ill = (c == 3);
      e_mn  = 0;
      m_cnt = t_n(ir);
    end else if (m_cnt > 0) begin
      e_vld = '0; e_mn = 1; e_ill = 0; m_cnt--;
      for (int u = 0; u < 3; u++) e_slot[u] = '0;
    end else begin
      e_vld = '0; e_mn = 0; e_ill = 0; last_code = -1;
      for (int u = 0; u < 3; u++) e_slot[u] = '0;
    end
    for (int u = 0; u < 3; u++) begin
      string tv;
      tv = (last_code < 0) ? "R12" : "R4";
      chk(opv[u] == e_vld[u], tv, opv[u], e_vld[u]);
      if (e_vld[u]) begin
        chk(grp[u*2 +: 2] == e_slot[u][1:0], "R6", grp[u*2 +: 2], e_slot[u][1:0]);
        chk(body[u*10 +: 10] == e_slot[u][11:2], "R5", body[u*10 +: 10], e_slot[u][11:2]);
      end else begin
        chk(grp[u*2 +: 2] == 2'b0 && body[u*10 +: 10] == 10'b0, "R7",
            {grp[u*2 +: 2], body[u*10 +: 10]}, 0);
      end
    end
    chk(mnop == e_mn, (last_code == 1) ? "R10" : "R8", mnop, e_mn);
    chk(ill == e_ill, "R11", ill, e_ill);
  endtask

  // drive inputs and compare combinational outputs
  task automatic drive_chk(input logic [63:0] w, input bit v);
    bit e_adv;
    ir = w; vld = v;
    #1;
    e_adv = v && m_cnt == 0;
    chk(adv == e_adv, (m_cnt > 0) ? "R9" : "R2", adv, e_adv);
    chk(eop == (e_adv && w[0]), "R2", eop, e_adv && w[0]);
    if (e_adv) chk(len == 3'(t_len(int'(w[2:1]))), "R3", len, t_len(int'(w[2:1])));
  endtask

  task automatic cyc(input logic [63:0] w, input bit v);
    edge_chk();
    drive_chk(w, v);
  endtask

  function automatic logic [63:0] mk(input int c, input int n);
    logic [63:0] w = {$urandom, $urandom};
    w[2:1] = 2'(c);
    if (c == 0) w[41:39] = 3'(n);
    if (c == 2) w[29:27] = 3'(n);
    return w;
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog R1 act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(opv == 0 && grp == 0 && body == 0 && !mnop && !ill, "R1",
        {opv, mnop, ill}, 0);
    rst_n = 1'b1;
    drive_chk('0, 0);
    edge_chk();
    chk(opv == 0 && !mnop && !ill, "R1", {opv, mnop, ill}, 0);
    drive_chk('0, 0);
    // directed: each template, N = 0 and max, back-to-back waits
    for (int c = 0; c < 4; c++) begin
      cyc(mk(c, 0), 1);
      cyc(mk(c, 7), 1);
      for (int k = 0; k < 9; k++) cyc(mk((c + k) % 4, k % 8), 1); // R9 waiting instr
      cyc('0, 0);
    end
    // R10: code 1 with every upper bit set
    cyc(64'hffff_ffff_ffff_fffb, 1);
    cyc(64'hffff_ffff_ffff_fffb, 1);
    cyc('0, 0);
    // R11: illegal code with count-looking bits set
    cyc(64'hffff_ffff_ffff_ffff, 1);
    cyc('0, 0);
    // random traffic
    for (int i = 0; i < 4000; i++)
      cyc(mk(int'($urandom_range(0, 3)), int'($urandom_range(0, 7))), ($urandom_range(0, 3) != 0));
    for (int i = 0; i < 10; i++) cyc('0, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule